// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler Tree

This block turns one system clock into a set of single-cycle enable strobes for a divided clock tree. A high-speed bus strobe is derived from the system clock. Two peripheral-bus strobes and one timer strobe per peripheral bus are derived from the high-speed strobe. An ADC strobe is derived from the second peripheral-bus strobe, and a system-timer tick fires on every eighth high-speed strobe. Every strobe is one system-clock cycle wide and stays in the system clock domain. Logic downstream uses these strobes as clock enables instead of running on derived clocks.

Each divider takes its ratio from a small select field. A change to a select field is only adopted when the divider reaches its terminal count, so a period that is already under way always completes. Each peripheral bus also has a vector of per-device enable bits. A device strobe is the bus strobe gated by that device's enable bit, which is registered once.

Top module: `bus_strobe_tree`

## Requirements
- R1: Reset clears all counters. After reset the high-speed and both peripheral-bus ratios are 1, the ADC ratio is 2, and all device enables are off. In the first cycle after reset, hs_stb, pb1_stb, pb2_stb, tmr1_stb and tmr2_stb are 1, while adc_stb, systick_stb and all device strobes are 0. adc_stb goes to 1 in the second cycle.
- R2: hs_div_sel selects the high-speed ratio. Values 0000 to 0111 select 1. Values 1000, 1001, 1010, 1011, 1100, 1101, 1110 and 1111 select 2, 4, 8, 16, 64, 128, 256 and 512. hs_stb is high on the last system cycle of each period.
- R3: Each peripheral-bus select (3 bits) counts hs_stb pulses. Values 000 to 011 select 1, and values 100, 101, 110 and 111 select 2, 4, 8 and 16. The bus strobe is high on the last high-speed pulse of each period.
- R4: adc_div_sel counts pb2_stb pulses. Values 00, 01, 10 and 11 select 2, 4, 6 and 8.
- R5: When a peripheral bus ratio is 1, its timer strobe equals the bus strobe. Otherwise the timer strobe pulses on the high-speed pulse at half the period and on the bus strobe, which gives twice the bus rate.
- R6: systick_stb pulses on every eighth hs_stb pulse, starting with the eighth one after reset.
- R7: Bit i of a device strobe vector is the bus strobe ANDed with bit i of that bus's enable input as it was sampled on the previous clock edge.
- R8: A change to a select field takes effect at that divider's next terminal count. The period under way completes at its old length, and the following period uses the new length.
- R9: A derived strobe is never high unless its source strobe is high in the same cycle. Bus strobes need hs_stb, and adc_stb needs pb2_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_div_sel | input | 4 | High-speed bus ratio select |
| pb1_div_sel | input | 3 | Peripheral bus 1 ratio select |
| pb2_div_sel | input | 3 | Peripheral bus 2 ratio select |
| adc_div_sel | input | 2 | ADC ratio select |
| pb1_en | input | N_PERIPH | Device enables on peripheral bus 1 |
| pb2_en | input | N_PERIPH | Device enables on peripheral bus 2 |
| hs_stb | output | 1 | High-speed bus strobe |
| pb1_stb | output | 1 | Peripheral bus 1 strobe |
| pb2_stb | output | 1 | Peripheral bus 2 strobe |
| tmr1_stb | output | 1 | Timer strobe of peripheral bus 1 |
| tmr2_stb | output | 1 | Timer strobe of peripheral bus 2 |
| adc_stb | output | 1 | ADC strobe |
| systick_stb | output | 1 | System-timer tick |
| pb1_dev_stb | output | N_PERIPH | Gated device strobes, bus 1 |
| pb2_dev_stb | output | N_PERIPH | Gated device strobes, bus 2 |

## Verification
The bench builds the block with N_PERIPH set to 4. This is narrow enough that walking and mixed enable patterns cover every device bit on both buses. The divider counter widths come from the package and are not reduced. The bench therefore reaches the full 512 high-speed ratio and the non-power-of-two ADC ratio of 6, each running over whole periods. It also steps through every peripheral and ADC select, including the select values that alias to a ratio of 1.

// File: rtl/clk_strobe_pkg.sv
package clk_strobe_pkg;

    localparam int HS_RW  = 10;   // holds ratios up to 512
    localparam int PB_RW  = 5;    // holds ratios up to 16
    localparam int ADC_RW = 4;    // holds ratios up to 8
    localparam int ST_RW  = 4;
    localparam int ST_RATIO = 8;

    typedef struct packed {
        logic hs;
        logic pb1;
        logic pb2;
        logic tm1;
        logic tm2;
        logic adc;
        logic systick;
    } strobe_t;

    function automatic logic [HS_RW-1:0] hs_ratio(input logic [3:0] sel);
        logic [3:0] sh;
        if (!sel[3]) return HS_RW'(1);
        // ratio 32 is skipped: upper half of codes shifts one extra step
        sh = {1'b0, sel[2:0]} + 4'd1 + (sel[2] ? 4'd1 : 4'd0);
        return HS_RW'(1) << sh;
    endfunction

    function automatic logic [PB_RW-1:0] pb_ratio(input logic [2:0] sel);
        logic [2:0] sh;
        if (!sel[2]) return PB_RW'(1);
        sh = {1'b0, sel[1:0]} + 3'd1;
        return PB_RW'(1) << sh;
    endfunction

    function automatic logic [ADC_RW-1:0] adc_ratio(input logic [1:0] sel);
        return ADC_RW'({sel, 1'b0}) + ADC_RW'(2);
    endfunction

endpackage

// File: rtl/strobe_div.sv
module strobe_div #(
    parameter int W           = 4,
    parameter int RESET_RATIO = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_in,
    input  logic [W-1:0] ratio_in,
    output logic         tick_out
);
    logic [W-1:0] cnt;
    logic [W-1:0] cur;
    logic         term;

    assign term     = (cnt == cur - W'(1));
    assign tick_out = tick_in & term;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            cur <= W'(RESET_RATIO);
        end else if (tick_in) begin
            if (term) begin
                cnt <= '0;
                cur <= ratio_in;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end

    // R9
    out_needs_in_chk: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> tick_in);

    // R8
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick_in && term) |=> $stable(cur));

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < cur);

endmodule

// File: rtl/bus_div.sv
module bus_div #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_in,
    input  logic [W-1:0] ratio_in,
    output logic         tick_out,
    output logic         tick_dbl
);
    logic [W-1:0] cnt;
    logic [W-1:0] cur;
    logic         term;
    logic         mid;

    assign term     = (cnt == cur - W'(1));
    // for a ratio of 1 the midpoint compare never matches; term covers it
    assign mid      = (cnt == (cur >> 1) - W'(1));
    assign tick_out = tick_in & term;
    assign tick_dbl = tick_in & (term | mid);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            cur <= W'(1);
        end else if (tick_in) begin
            if (term) begin
                cnt <= '0;
                cur <= ratio_in;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end

    // R5
    dbl_covers_chk: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> tick_dbl);

    // R9
    dbl_needs_in_chk: assert property (@(posedge clk) disable iff (rst)
        tick_dbl |-> tick_in);

    // R8
    bus_ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick_in && term) |=> $stable(cur));

endmodule

// File: rtl/periph_gate.sv
module periph_gate #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_stb,
    input  logic [N-1:0] en_in,
    output logic [N-1:0] stb_out
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_in;
    end

    assign stb_out = en_q & {N{bus_stb}};

    // R7
    gate_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (|stb_out) |-> bus_stb);

    // R7
    gate_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_out & ~$past(en_in)) == '0);

endmodule

// File: rtl/bus_strobe_tree.sv
module bus_strobe_tree
    import clk_strobe_pkg::*;
#(
    parameter int N_PERIPH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          hs_div_sel,
    input  logic [2:0]          pb1_div_sel,
    input  logic [2:0]          pb2_div_sel,
    input  logic [1:0]          adc_div_sel,
    input  logic [N_PERIPH-1:0] pb1_en,
    input  logic [N_PERIPH-1:0] pb2_en,
    output logic                hs_stb,
    output logic                pb1_stb,
    output logic                pb2_stb,
    output logic                tmr1_stb,
    output logic                tmr2_stb,
    output logic                adc_stb,
    output logic                systick_stb,
    output logic [N_PERIPH-1:0] pb1_dev_stb,
    output logic [N_PERIPH-1:0] pb2_dev_stb
);
    localparam int NBUS = 2;

    strobe_t             s;
    logic [2:0]          pb_sel [NBUS];
    logic [NBUS-1:0]     pb_s;
    logic [NBUS-1:0]     tm_s;
    logic [N_PERIPH-1:0] en_a  [NBUS];
    logic [N_PERIPH-1:0] dev_a [NBUS];

    assign pb_sel[0] = pb1_div_sel;
    assign pb_sel[1] = pb2_div_sel;
    assign en_a[0]   = pb1_en;
    assign en_a[1]   = pb2_en;

    strobe_div #(.W(HS_RW), .RESET_RATIO(1)) u_hs (
        .clk      (clk),
        .rst      (rst),
        .tick_in  (1'b1),
        .ratio_in (hs_ratio(hs_div_sel)),
        .tick_out (s.hs)
    );

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        bus_div #(.W(PB_RW)) u_pb (
            .clk      (clk),
            .rst      (rst),
            .tick_in  (s.hs),
            .ratio_in (pb_ratio(pb_sel[b])),
            .tick_out (pb_s[b]),
            .tick_dbl (tm_s[b])
        );

        periph_gate #(.N(N_PERIPH)) u_gate (
            .clk     (clk),
            .rst     (rst),
            .bus_stb (pb_s[b]),
            .en_in   (en_a[b]),
            .stb_out (dev_a[b])
        );
    end

    assign s.pb1 = pb_s[0];
    assign s.pb2 = pb_s[1];
    assign s.tm1 = tm_s[0];
    assign s.tm2 = tm_s[1];

    strobe_div #(.W(ADC_RW), .RESET_RATIO(2)) u_adc (
        .clk      (clk),
        .rst      (rst),
        .tick_in  (s.pb2),
        .ratio_in (adc_ratio(adc_div_sel)),
        .tick_out (s.adc)
    );

    strobe_div #(.W(ST_RW), .RESET_RATIO(ST_RATIO)) u_systick (
        .clk      (clk),
        .rst      (rst),
        .tick_in  (s.hs),
        .ratio_in (ST_RW'(ST_RATIO)),
        .tick_out (s.systick)
    );

    assign hs_stb      = s.hs;
    assign pb1_stb     = s.pb1;
    assign pb2_stb     = s.pb2;
    assign tmr1_stb    = s.tm1;
    assign tmr2_stb    = s.tm2;
    assign adc_stb     = s.adc;
    assign systick_stb = s.systick;
    assign pb1_dev_stb = dev_a[0];
    assign pb2_dev_stb = dev_a[1];

    // R3
    pb_under_hs_chk: assert property (@(posedge clk) disable iff (rst)
        (pb1_stb || pb2_stb || tmr1_stb || tmr2_stb) |-> hs_stb);

    // R4
    adc_under_pb2_chk: assert property (@(posedge clk) disable iff (rst)
        adc_stb |-> pb2_stb);

    // R6
    systick_under_hs_chk: assert property (@(posedge clk) disable iff (rst)
        systick_stb |-> hs_stb);

endmodule

// File: tb/bus_strobe_tree_tb.sv
module bus_strobe_tree_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   hs_div_sel = '0;
    logic [2:0]   pb1_div_sel = '0;
    logic [2:0]   pb2_div_sel = '0;
    logic [1:0]   adc_div_sel = '0;
    logic [N-1:0] pb1_en = '0;
    logic [N-1:0] pb2_en = '0;
    logic         hs_stb, pb1_stb, pb2_stb, tmr1_stb, tmr2_stb, adc_stb, systick_stb;
    logic [N-1:0] pb1_dev_stb, pb2_dev_stb;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    bus_strobe_tree #(.N_PERIPH(N)) u_dut (
        .clk(clk), .rst(rst),
        .hs_div_sel(hs_div_sel), .pb1_div_sel(pb1_div_sel),
        .pb2_div_sel(pb2_div_sel), .adc_div_sel(adc_div_sel),
        .pb1_en(pb1_en), .pb2_en(pb2_en),
        .hs_stb(hs_stb), .pb1_stb(pb1_stb), .pb2_stb(pb2_stb),
        .tmr1_stb(tmr1_stb), .tmr2_stb(tmr2_stb), .adc_stb(adc_stb),
        .systick_stb(systick_stb),
        .pb1_dev_stb(pb1_dev_stb), .pb2_dev_stb(pb2_dev_stb)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ratio decoding written from the requirements
    function automatic int m_hs(input logic [3:0] c);
        case (c)
            4'b1000: return 2;   4'b1001: return 4;
            4'b1010: return 8;   4'b1011: return 16;
            4'b1100: return 64;  4'b1101: return 128;
            4'b1110: return 256; 4'b1111: return 512;
            default: return 1;
        endcase
    endfunction
    function automatic int m_pb(input logic [2:0] c);
        case (c)
            3'b100: return 2; 3'b101: return 4;
            3'b110: return 8; 3'b111: return 16;
            default: return 1;
        endcase
    endfunction
    function automatic int m_adc(input logic [1:0] c);
        return 2 * (int'(c) + 1);
    endfunction

    typedef struct {
        bit hs, p1, p2, t1, t2, ad, st;
        bit [N-1:0] d1, d2;
    } exp_t;

    exp_t exp_q[$];

    // model state
    int mh, m1, m2, ma, ms;
    int rh, r1, r2, ra;
    bit [N-1:0] e1q, e2q;

    task automatic model_reset();
        mh = 0; m1 = 0; m2 = 0; ma = 0; ms = 0;
        rh = 1; r1 = 1; r2 = 1; ra = 2;
        e1q = '0; e2q = '0;
    endtask

    // driver side of the scoreboard: predict this cycle, push, then advance
    task automatic model_push_and_step();
        exp_t e;
        e.hs = (mh == rh - 1);
        e.p1 = e.hs && (m1 == r1 - 1);
        e.p2 = e.hs && (m2 == r2 - 1);
        e.t1 = e.hs && ((m1 == r1 - 1) || (m1 == r1 / 2 - 1));
        e.t2 = e.hs && ((m2 == r2 - 1) || (m2 == r2 / 2 - 1));
        e.ad = e.p2 && (ma == ra - 1);
        e.st = e.hs && (ms == 7);
        e.d1 = e.p1 ? e1q : '0;
        e.d2 = e.p2 ? e2q : '0;
        exp_q.push_back(e);
        e1q = pb1_en;
        e2q = pb2_en;
        if (e.hs) begin mh = 0; rh = m_hs(hs_div_sel); end else mh++;
        if (e.hs) begin
            if (e.p1) begin m1 = 0; r1 = m_pb(pb1_div_sel); end else m1++;
            if (e.p2) begin m2 = 0; r2 = m_pb(pb2_div_sel); end else m2++;
            ms = (ms == 7) ? 0 : ms + 1;
        end
        if (e.p2) begin
            if (e.ad) begin ma = 0; ra = m_adc(adc_div_sel); end else ma++;
        end
    endtask

    // monitor: pop expected item and compare against the ports
    always @(negedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            exp_t x;
            model_push_and_step();
            if (exp_q.size() == 0) begin
                chk("R2", "queue empty", 0, 1);
            end else begin
                x = exp_q.pop_front();
                chk("R2", "hs_stb",      int'(hs_stb),      int'(x.hs));
                chk("R3", "pb1_stb",     int'(pb1_stb),     int'(x.p1));
                chk("R3", "pb2_stb",     int'(pb2_stb),     int'(x.p2));
                chk("R5", "tmr1_stb",    int'(tmr1_stb),    int'(x.t1));
                chk("R5", "tmr2_stb",    int'(tmr2_stb),    int'(x.t2));
                chk("R4", "adc_stb",     int'(adc_stb),     int'(x.ad));
                chk("R6", "systick_stb", int'(systick_stb), int'(x.st));
                chk("R7", "pb1_dev_stb", int'(pb1_dev_stb), int'(x.d1));
                chk("R7", "pb2_dev_stb", int'(pb2_dev_stb), int'(x.d2));
            end
            chk("R9", "pb/tmr without hs",
                int'((pb1_stb || pb2_stb || tmr1_stb || tmr2_stb) && !hs_stb), 0);
            chk("R9", "adc without pb2", int'(adc_stb && !pb2_stb), 0);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_hs(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!hs_stb);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : driver
        int g;
        logic [3:0] hs_list [9];
        hs_list = '{4'b0110, 4'b1000, 4'b1001, 4'b1010, 4'b1011,
                    4'b1100, 4'b1101, 4'b1110, 4'b1111};
        pb1_en = '1;
        pb2_en = '1;
        repeat (4) step();
        rst = 1'b0;
        #1;
        // R1 first cycle after reset: reset state still held in the counters
        chk("R1", "hs_stb after reset",  int'(hs_stb), 1);
        chk("R1", "pb1_stb after reset", int'(pb1_stb), 1);
        chk("R1", "pb2_stb after reset", int'(pb2_stb), 1);
        chk("R1", "tmr1_stb after reset", int'(tmr1_stb), 1);
        chk("R1", "adc_stb after reset", int'(adc_stb), 0);
        chk("R1", "systick after reset", int'(systick_stb), 0);
        chk("R1", "dev strobes after reset", int'({pb1_dev_stb, pb2_dev_stb}), 0);
        step(); #1;
        chk("R1", "adc_stb second cycle", int'(adc_stb), 1);
        chk("R7", "pb1_dev_stb after enable", int'(pb1_dev_stb), int'({N{1'b1}}));

        // high-speed sweep with mixed bus/adc selects and enable patterns
        for (int i = 0; i < 9; i++) begin
            hs_div_sel  = hs_list[i];
            pb1_div_sel = 3'(i);
            pb2_div_sel = 3'(i + 3);
            adc_div_sel = 2'(i);
            pb1_en      = N'(1 << (i % N));
            pb2_en      = N'(4'b1010 ^ i);
            repeat (300) step();
        end

        // bus and adc sweep at high-speed ratio 1
        hs_div_sel = 4'b0000;
        for (int p = 0; p < 8; p++) begin
            for (int a = 0; a < 4; a++) begin
                pb1_div_sel = 3'(p);
                pb2_div_sel = 3'(7 - p);
                adc_div_sel = 2'(a);
                pb1_en      = N'(p + a);
                pb2_en      = ~N'(p);
                repeat (64) step();
            end
        end

        // R8: change mid-period, old period completes, then new one applies
        hs_div_sel = 4'b1010;
        wait_hs(g);
        wait_hs(g);
        chk("R8", "hs period at ratio 8", g, 8);
        step(); step();
        hs_div_sel = 4'b1000;
        wait_hs(g);
        chk("R8", "period after mid-count change", g + 2, 8);
        wait_hs(g);
        chk("R8", "period with new ratio 2", g, 2);
        repeat (20) step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule